// File: doc/BRIEF.md
# Prioritized Interrupt Bank

This block gathers 32 interrupt request lines into one bank and presents at most two requests to a processor: a normal interrupt output and a fast interrupt output. Each line has its own configuration word. The word sets whether the line is latched on a rising edge or followed as a level, whether it goes to the fast output, and its 5-bit priority. The bank keeps a status vector of pending requests. It applies a per-line mask and a bank-wide output mask. For each output it picks the best pending, unmasked line.

Each output channel is a two-state machine. In `CH_IDLE` the channel waits for a candidate. The transition *grant* (`CH_IDLE` to `CH_HELD`) happens when a candidate exists, and it stores the winning line number. In `CH_HELD` the output is raised and the stored number is frozen. The transition *release* (`CH_HELD` to `CH_IDLE`) happens on a software acknowledge written to the control register. A new arbitration follows on the next clock.

Banks can be chained. The normal output of a second bank (instantiated with a nonzero bank index) drives one input line of the first bank. Only bank index 0 can route lines to its fast output.

Top module: `intc_bank`

Register map, byte addresses on `bus_addr_i`:
- 0x00: status, one pending bit per line.
- 0x04: line mask.
- 0x08: normal-output line number.
- 0x0C: fast-output line number.
- 0x10: control, write-only.
- 0x14: output mask, bit 0.
- 0x80 + 4·n: configuration word of line n.

## Requirements
- R1: After reset the line mask reads 0xFFFFFFFF, the status reads 0, the output mask reads 0 and both outputs are low.
- R2: With configuration bit 1 = 0 (edge mode), a rising edge on a line sets its status bit on the next clock. The bit stays set after the input falls. An unmasked line raises its output on the second clock edge after the input rises.
- R3: With configuration bit 1 = 1 (level mode), the status bit of a line equals the line input sampled on the previous clock.
- R4: A mask bit of 1 keeps its line out of arbitration while its status bit still latches. Clearing the mask bit lets the line win on the following clock.
- R5: The winner is the eligible line with the smallest priority value in configuration bits 6:2. Equal values go to the lowest line number.
- R6: Configuration bit 0 = 1 sends a line to the fast output, and its number reads at 0x0C. In a bank with a nonzero index, bit 0 reads as 0, the line goes to the normal output, and the fast output never rises.
- R7: While an output is high, its line number and the output stay frozen, even if the input falls or a better line arrives.
- R8: Writing control bit 0 = 1 releases the normal output, and bit 1 = 1 releases the fast output (0x03 releases both). The edge-mode status bit of the released line clears, and a new winner appears one clock later.
- R9: A write to 0x00 keeps only the edge-mode status bits whose data bit is 1, so writing 0 clears them all.
- R10: Output mask bit 0 = 1 holds both outputs low, but arbitration and freezing go on. Writing 0 shows the held request at once.
- R11: Read data appears the clock after `bus_rd_i`. A configuration word reads back in bits 6:0.
- R12: When a second bank's normal output feeds a level-mode line, releasing only the first bank re-raises its output. Releasing the second bank first and then the first bank leaves both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 32 | Interrupt request lines, synchronous to clk_i |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one clock after the strobe |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |
| irq_src_o | output | 5 | Frozen line number of the normal output |
| fiq_src_o | output | 5 | Frozen line number of the fast output |

## Verification
The hardest situation to reach is the chained one. A request must travel through a second bank, through the first bank's level-mode line, and reach the first bank's output, and the order of releases decides whether that output comes back. The bench wires two instances together and pulses a line of the second bank. It then releases the first bank alone and checks that its output re-rises. Finally it releases the second bank and then the first, and checks that both stay low. The frozen-winner case is reached by raising a better line while a worse one is already held.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_HELD = 1'b1
    } ch_state_e;

    localparam logic [7:0] ADDR_STATUS   = 8'h00;
    localparam logic [7:0] ADDR_MASK     = 8'h04;
    localparam logic [7:0] ADDR_IRQ_SRC  = 8'h08;
    localparam logic [7:0] ADDR_FIQ_SRC  = 8'h0C;
    localparam logic [7:0] ADDR_CTRL     = 8'h10;
    localparam logic [7:0] ADDR_GMASK    = 8'h14;
    localparam logic [7:0] ADDR_LVL_BASE = 8'h80;

    localparam int CTRL_IRQ_ACK_BIT = 0;
    localparam int CTRL_FIQ_ACK_BIT = 1;

endpackage

// File: rtl/intc_cfg_regs.sv
`timescale 1ns/1ps
module intc_cfg_regs
    import intc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 5,
    parameter bit FIQ_OK    = 1'b1
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               wr_i,
    input  logic [7:0]                         addr_i,
    input  logic [31:0]                        wdata_i,
    output logic [NUM_LINES-1:0]               mask_o,
    output logic                               gmask_o,
    output logic [NUM_LINES-1:0]               fiq_sel_o,
    output logic [NUM_LINES-1:0]               trig_o,
    output logic [NUM_LINES-1:0][PRIO_W-1:0]   prio_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_o  <= '1;
            gmask_o <= 1'b0;
        end else if (wr_i) begin
            if (addr_i == ADDR_MASK)  mask_o  <= wdata_i[NUM_LINES-1:0];
            if (addr_i == ADDR_GMASK) gmask_o <= wdata_i[0];
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_lvl
        localparam logic [7:0] LVL_ADDR = 8'(ADDR_LVL_BASE + 4 * g);
        logic              fiq_r;
        logic              trig_r;
        logic [PRIO_W-1:0] prio_r;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                fiq_r  <= 1'b0;
                trig_r <= 1'b0;
                prio_r <= '0;
            end else if (wr_i && addr_i == LVL_ADDR) begin
                fiq_r  <= wdata_i[0] & FIQ_OK;
                trig_r <= wdata_i[1];
                prio_r <= wdata_i[2 +: PRIO_W];
            end
        end

        assign fiq_sel_o[g] = fiq_r;
        assign trig_o[g]    = trig_r;
        assign prio_o[g]    = prio_r;
    end

endmodule

// File: rtl/intc_pending.sv
`timescale 1ns/1ps
module intc_pending #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LINES-1:0] lines_i,
    input  logic [NUM_LINES-1:0] trig_i,
    input  logic                 stat_wr_i,
    input  logic [NUM_LINES-1:0] stat_keep_i,
    input  logic [NUM_LINES-1:0] clr_i,
    output logic [NUM_LINES-1:0] pend_o
);

    logic [NUM_LINES-1:0] line_q;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] edge_next;
    logic                 past_ok;

    assign rise = lines_i & ~line_q;

    always_comb begin
        edge_next = pend_o;
        if (stat_wr_i) edge_next = edge_next & stat_keep_i;
        edge_next = (edge_next & ~clr_i) | rise;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            line_q  <= '0;
            pend_o  <= '0;
            past_ok <= 1'b0;
        end else begin
            line_q  <= lines_i;
            pend_o  <= (trig_i & lines_i) | (~trig_i & edge_next);
            past_ok <= 1'b1;
        end
    end

    // R2
    edge_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((rise & ~trig_i) != '0) |=>
        ((pend_o & $past(rise & ~trig_i)) == $past(rise & ~trig_i)));

    // R3
    level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok |-> ((pend_o & $past(trig_i)) == ($past(lines_i) & $past(trig_i))));

endmodule

// File: rtl/intc_arbiter.sv
`timescale 1ns/1ps
module intc_arbiter #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 5,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]             req_i,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_i,
    output logic                             valid_o,
    output logic [IDX_W-1:0]                 idx_o
);

    logic              found;
    logic [PRIO_W-1:0] best;
    logic [IDX_W-1:0]  best_idx;

    always_comb begin
        found    = 1'b0;
        best     = '1;
        best_idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (req_i[i] && (!found || prio_i[i] < best)) begin
                found    = 1'b1;
                best     = prio_i[i];
                best_idx = IDX_W'(i);
            end
        end
        valid_o = found;
        idx_o   = best_idx;
    end

endmodule

// File: rtl/intc_channel.sv
`timescale 1ns/1ps
module intc_channel
    import intc_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_valid_i,
    input  logic [IDX_W-1:0] req_idx_i,
    input  logic             ack_i,
    output logic             active_o,
    output logic             release_o,
    output logic [IDX_W-1:0] src_o
);

    ch_state_e state_q, state_d;
    logic      grant;

    always_comb begin : next_state
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (req_valid_i) state_d = CH_HELD;
            CH_HELD: if (ack_i)       state_d = CH_IDLE;
            default:                  state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin : state_reg
        if (!rst_ni) begin
            state_q <= CH_IDLE;
            src_o   <= '0;
        end else begin
            state_q <= state_d;
            if (grant) src_o <= req_idx_i;
        end
    end

    always_comb begin : outputs
        grant     = (state_q == CH_IDLE) && req_valid_i;
        active_o  = (state_q == CH_HELD);
        release_o = (state_q == CH_HELD) && ack_i;
    end

    // R7
    held_src_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CH_HELD && !ack_i) |=> ($stable(src_o) && state_q == CH_HELD));

endmodule

// File: rtl/intc_bank.sv
`timescale 1ns/1ps
module intc_bank
    import intc_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int PRIO_W     = 5,
    parameter int BANK_INDEX = 0,
    localparam int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [31:0]      lines_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [7:0]       bus_addr_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    output logic             irq_o,
    output logic             fiq_o,
    output logic [4:0]       irq_src_o,
    output logic [4:0]       fiq_src_o
);

    localparam bit FIQ_OK = (BANK_INDEX == 0);
    localparam logic [NUM_LINES-1:0] LSB_ONE = NUM_LINES'(1);

    logic [NUM_LINES-1:0]             mask, fiq_sel, trig, pend, clr;
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio;
    logic                             gmask;
    logic [NUM_LINES-1:0]             eligible, irq_req, fiq_req;
    logic                             irq_valid, fiq_valid;
    logic [IDX_W-1:0]                 irq_win, fiq_win, irq_src, fiq_src;
    logic                             irq_active, fiq_active, irq_rel, fiq_rel;
    logic                             stat_wr, ctrl_wr, irq_ack, fiq_ack;
    logic [NUM_LINES-1:0]             irq_src_hot, fiq_src_hot;
    logic [31:0]                      rd_val;

    assign stat_wr = bus_wr_i && (bus_addr_i == ADDR_STATUS);
    assign ctrl_wr = bus_wr_i && (bus_addr_i == ADDR_CTRL);
    assign irq_ack = ctrl_wr && bus_wdata_i[CTRL_IRQ_ACK_BIT];
    assign fiq_ack = ctrl_wr && bus_wdata_i[CTRL_FIQ_ACK_BIT];

    intc_cfg_regs #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .FIQ_OK(FIQ_OK)) cfg_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .mask_o(mask), .gmask_o(gmask),
        .fiq_sel_o(fiq_sel), .trig_o(trig), .prio_o(prio)
    );

    intc_pending #(.NUM_LINES(NUM_LINES)) pend_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .lines_i(lines_i[NUM_LINES-1:0]),
        .trig_i(trig), .stat_wr_i(stat_wr),
        .stat_keep_i(bus_wdata_i[NUM_LINES-1:0]), .clr_i(clr), .pend_o(pend)
    );

    assign eligible = pend & ~mask;
    assign irq_req  = eligible & ~fiq_sel;
    assign fiq_req  = eligible & fiq_sel;

    intc_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) irq_arb_i (
        .req_i(irq_req), .prio_i(prio), .valid_o(irq_valid), .idx_o(irq_win)
    );

    intc_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) fiq_arb_i (
        .req_i(fiq_req), .prio_i(prio), .valid_o(fiq_valid), .idx_o(fiq_win)
    );

    intc_channel #(.IDX_W(IDX_W)) irq_ch_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(irq_valid), .req_idx_i(irq_win),
        .ack_i(irq_ack), .active_o(irq_active), .release_o(irq_rel), .src_o(irq_src)
    );

    intc_channel #(.IDX_W(IDX_W)) fiq_ch_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(fiq_valid), .req_idx_i(fiq_win),
        .ack_i(fiq_ack), .active_o(fiq_active), .release_o(fiq_rel), .src_o(fiq_src)
    );

    assign irq_src_hot = LSB_ONE << irq_src;
    assign fiq_src_hot = LSB_ONE << fiq_src;
    assign clr = (irq_rel ? irq_src_hot : '0) | (fiq_rel ? fiq_src_hot : '0);

    assign irq_o     = irq_active && !gmask;
    assign fiq_o     = fiq_active && !gmask;
    assign irq_src_o = 5'(irq_src);
    assign fiq_src_o = 5'(fiq_src);

    always_comb begin
        rd_val = '0;
        case (bus_addr_i)
            ADDR_STATUS:  rd_val = 32'(pend);
            ADDR_MASK:    rd_val = 32'(mask);
            ADDR_IRQ_SRC: rd_val = 32'(irq_src);
            ADDR_FIQ_SRC: rd_val = 32'(fiq_src);
            ADDR_GMASK:   rd_val = 32'(gmask);
            default: begin
                for (int g = 0; g < NUM_LINES; g++) begin
                    if (bus_addr_i == 8'(ADDR_LVL_BASE + 4 * g))
                        rd_val = 32'({prio[g], trig[g], fiq_sel[g]});
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       bus_rdata_o <= '0;
        else if (bus_rd_i) bus_rdata_o <= rd_val;
    end

    // R4
    irq_grant_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_active) |-> (($past(irq_req) & irq_src_hot) != '0));

    // R6
    fiq_grant_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fiq_active) |-> (($past(fiq_req) & fiq_src_hot) != '0));

    if (!FIQ_OK) begin : g_no_fiq
        // R6
        fiq_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !fiq_o && fiq_sel == '0);
    end

endmodule

// File: tb/intc_bank_tb_top.sv
`timescale 1ns/1ps
module intc_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [30:0] m_lines = '0;
    logic [31:0] s_lines = '0;
    logic        m_wr = 0, m_rd = 0, s_wr = 0, s_rd = 0;
    logic [7:0]  m_addr = '0, s_addr = '0;
    logic [31:0] m_wdata = '0, s_wdata = '0;
    logic [31:0] m_rdata, s_rdata;
    logic        m_irq, m_fiq, s_irq, s_fiq;
    logic [4:0]  m_isrc, m_fsrc, s_isrc, s_fsrc;

    int checks = 0;
    int fails  = 0;

    intc_bank #(.BANK_INDEX(0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .lines_i({s_irq, m_lines}),
        .bus_wr_i(m_wr), .bus_rd_i(m_rd), .bus_addr_i(m_addr), .bus_wdata_i(m_wdata),
        .bus_rdata_o(m_rdata), .irq_o(m_irq), .fiq_o(m_fiq),
        .irq_src_o(m_isrc), .fiq_src_o(m_fsrc)
    );

    intc_bank #(.BANK_INDEX(1)) sub_i (
        .clk_i(clk), .rst_ni(rst_n), .lines_i(s_lines),
        .bus_wr_i(s_wr), .bus_rd_i(s_rd), .bus_addr_i(s_addr), .bus_wdata_i(s_wdata),
        .bus_rdata_o(s_rdata), .irq_o(s_irq), .fiq_o(s_fiq),
        .irq_src_o(s_isrc), .fiq_src_o(s_fsrc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit sub, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (sub) begin s_wr = 1; s_addr = a; s_wdata = d; end
        else     begin m_wr = 1; m_addr = a; m_wdata = d; end
        @(negedge clk);
        m_wr = 0; s_wr = 0;
    endtask

    task automatic rd(input bit sub, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        if (sub) begin s_rd = 1; s_addr = a; end
        else     begin m_rd = 1; m_addr = a; end
        @(negedge clk);
        m_rd = 0; s_rd = 0;
        d = sub ? s_rdata : m_rdata;
    endtask

    task automatic pulse_m(input logic [30:0] bits);
        @(negedge clk); m_lines = m_lines | bits;
        @(negedge clk); m_lines = m_lines & ~bits;
    endtask

    task automatic pulse_s(input logic [31:0] bits);
        @(negedge clk); s_lines = s_lines | bits;
        @(negedge clk); s_lines = s_lines & ~bits;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(0, 8'h04, d); chk("R1", "mask after reset", d, 32'hFFFF_FFFF);
        rd(0, 8'h00, d); chk("R1", "status after reset", d, 0);
        rd(0, 8'h14, d); chk("R1", "output mask after reset", d, 0);
        chk("R1", "irq low", 32'(m_irq), 0);
        chk("R1", "fiq low", 32'(m_fiq), 0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(0, 8'h04, ~(32'h1 << 5));
        @(negedge clk); m_lines[5] = 1'b1;
        @(negedge clk); chk("R2", "irq one edge after rise", 32'(m_irq), 0);
        m_lines[5] = 1'b0;
        @(negedge clk); chk("R2", "irq two edges after rise", 32'(m_irq), 1);
        chk("R2", "irq src", 32'(m_isrc), 5);
        rd(0, 8'h00, d); chk("R2", "edge latched after input fell", d, 32'h1 << 5);
        wr(0, 8'h10, 32'h1); chk("R8", "irq low after ack", 32'(m_irq), 0);
        idle(2); chk("R8", "irq stays low", 32'(m_irq), 0);
        rd(0, 8'h00, d); chk("R8", "edge latch cleared by ack", d, 0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(0, 8'h9C, 32'h2);
        wr(0, 8'h04, ~((32'h1 << 5) | (32'h1 << 7)));
        @(negedge clk); m_lines[7] = 1'b1;
        idle(2); chk("R3", "level irq", 32'(m_irq), 1);
        chk("R3", "level src", 32'(m_isrc), 7);
        rd(0, 8'h00, d); chk("R3", "status follows high", d, 32'h1 << 7);
        m_lines[7] = 1'b0;
        idle(2);
        rd(0, 8'h00, d); chk("R3", "status follows low", d, 0);
        chk("R7", "output frozen after input fell", 32'(m_irq), 1);
        wr(0, 8'h10, 32'h1); idle(2);
        chk("R8", "level line idle after ack", 32'(m_irq), 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        pulse_m(31'h1 << 9); idle(2);
        chk("R4", "masked line no irq", 32'(m_irq), 0);
        rd(0, 8'h00, d); chk("R4", "masked line still latched", d, 32'h1 << 9);
        wr(0, 8'h04, ~((32'h1 << 5) | (32'h1 << 7) | (32'h1 << 9)));
        idle(1); chk("R4", "irq after unmask", 32'(m_irq), 1);
        chk("R4", "src after unmask", 32'(m_isrc), 9);
        wr(0, 8'h10, 32'h1); idle(1);
    endtask

    task automatic t_prio();
        wr(0, 8'h8C, 32'(10 << 2));
        wr(0, 8'hB0, 32'(4 << 2));
        wr(0, 8'hD0, 32'(4 << 2));
        wr(0, 8'h04, ~((32'h1 << 3) | (32'h1 << 12) | (32'h1 << 20)));
        pulse_m((31'h1 << 3) | (31'h1 << 12) | (31'h1 << 20)); idle(1);
        chk("R5", "tie to lower line", 32'(m_isrc), 12);
        wr(0, 8'h10, 32'h1); idle(1);
        chk("R5", "second winner", 32'(m_isrc), 20);
        chk("R8", "re-arbitrated irq", 32'(m_irq), 1);
        wr(0, 8'h10, 32'h1); idle(1);
        chk("R5", "third winner", 32'(m_isrc), 3);
        wr(0, 8'h10, 32'h1); idle(1);
        chk("R8", "all served", 32'(m_irq), 0);
    endtask

    task automatic t_freeze();
        pulse_m(31'h1 << 3); idle(1);
        chk("R7", "worse line held", 32'(m_isrc), 3);
        pulse_m(31'h1 << 12); idle(2);
        chk("R7", "src frozen on better arrival", 32'(m_isrc), 3);
        chk("R7", "irq still high", 32'(m_irq), 1);
        wr(0, 8'h10, 32'h1); idle(1);
        chk("R8", "better line next", 32'(m_isrc), 12);
        wr(0, 8'h10, 32'h1); idle(1);
    endtask

    task automatic t_fiq();
        logic [31:0] d;
        wr(0, 8'h84, 32'h1);
        wr(0, 8'h04, ~((32'h1 << 1) | (32'h1 << 2)));
        pulse_m((31'h1 << 1) | (31'h1 << 2)); idle(1);
        chk("R6", "fiq high", 32'(m_fiq), 1);
        chk("R6", "fiq src", 32'(m_fsrc), 1);
        chk("R6", "irq takes other line", 32'(m_isrc), 2);
        rd(0, 8'h0C, d); chk("R11", "fiq src register", d, 1);
        rd(0, 8'h08, d); chk("R11", "irq src register", d, 2);
        rd(0, 8'h84, d); chk("R11", "config word readback", d, 1);
        wr(0, 8'h10, 32'h3);
        chk("R8", "both released irq", 32'(m_irq), 0);
        chk("R8", "both released fiq", 32'(m_fiq), 0);
        idle(2);
        chk("R8", "fiq stays low", 32'(m_fiq), 0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        wr(0, 8'h04, 32'hFFFF_FFFF);
        pulse_m((31'h1 << 4) | (31'h1 << 6)); idle(1);
        rd(0, 8'h00, d); chk("R9", "two latched", d, 32'h50);
        wr(0, 8'h00, ~(32'h1 << 4));
        rd(0, 8'h00, d); chk("R9", "zero bit cleared", d, 32'h40);
        wr(0, 8'h00, 32'h0);
        rd(0, 8'h00, d); chk("R9", "write zero clears all", d, 0);
    endtask

    task automatic t_gmask();
        logic [31:0] d;
        wr(0, 8'h04, ~(32'h1 << 4));
        wr(0, 8'h14, 32'h1);
        pulse_m(31'h1 << 4); idle(2);
        chk("R10", "blocked irq", 32'(m_irq), 0);
        rd(0, 8'h08, d); chk("R10", "arbitration continued", d, 4);
        wr(0, 8'h14, 32'h0);
        chk("R10", "held request shown", 32'(m_irq), 1);
        wr(0, 8'h10, 32'h1); idle(1);
    endtask

    task automatic t_cascade();
        wr(0, 8'hFC, 32'h2);
        wr(0, 8'h04, ~(32'h1 << 31));
        wr(1, 8'h04, ~(32'h1 << 8));
        pulse_s(32'h1 << 8); idle(3);
        chk("R12", "first bank irq", 32'(m_irq), 1);
        chk("R12", "first bank src", 32'(m_isrc), 31);
        chk("R12", "second bank src", 32'(s_isrc), 8);
        wr(0, 8'h10, 32'h1);
        chk("R12", "first bank dropped", 32'(m_irq), 0);
        idle(1); chk("R12", "first bank re-raised", 32'(m_irq), 1);
        wr(1, 8'h10, 32'h1); idle(2);
        chk("R12", "second bank low", 32'(s_irq), 0);
        wr(0, 8'h10, 32'h1); idle(3);
        chk("R12", "first bank stays low", 32'(m_irq), 0);
    endtask

    task automatic t_sub_fiq();
        logic [31:0] d;
        wr(0, 8'h04, 32'hFFFF_FFFF);
        wr(1, 8'h84, 32'h1);
        rd(1, 8'h84, d); chk("R6", "fiq bit reads 0 in bank 1", d, 0);
        wr(1, 8'h04, ~(32'h1 << 1));
        pulse_s(32'h1 << 1); idle(1);
        chk("R6", "bank 1 fiq never rises", 32'(s_fiq), 0);
        chk("R6", "bank 1 line on irq", 32'(s_irq), 1);
        chk("R6", "bank 1 irq src", 32'(s_isrc), 1);
        wr(1, 8'h10, 32'h1); idle(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_edge();
        t_level();
        t_mask();
        t_prio();
        t_freeze();
        t_fiq();
        t_status();
        t_gmask();
        t_cascade();
        t_sub_fiq();
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule